// File: doc/BRIEF.md
# Host Data Word Packing Buffer

This block sits between a 16-bit host data register and the byte-serial sequencer of a two-wire serial bus controller. It keeps a single four-byte store with two independent occupancy counts, one for bytes waiting to go out and one for bytes that have come in. Host writes of a full word or of a single trailing byte are packed into the outgoing queue. The sequencer draws outgoing bytes one at a time, oldest first, and hands received bytes back one at a time. A host read hands out the two oldest received bytes at once. A control input picks which half of the 16-bit word carries the earlier byte.

Every host access also produces one-cycle event pulses for the neighbouring status logic. A write clears the transmit-underflow and transmit-ready flags. A read clears the receive-ready and receive-overrun flags, and in master-receiver mode it also sets access-ready and drops the master flag. A read of an empty store raises a bus-data-empty event and returns zero instead of stalling. Both kinds of access pulse a kick to the sequencer. An access that would overfill the store is discarded and raises an overflow event.

Top module: `i2cdp_buffer`

## Requirements
- R1: After a synchronous reset both counts are zero and every valid and event output is low.
- R2: A word write (host_wr=1, host_wr_byte=0) with tx_count at most DEPTH-2 adds 2 to tx_count one cycle later. With ctl_swap=0 the sequencer sends host_wdata[7:0] before host_wdata[15:8]. With ctl_swap=1 it sends host_wdata[15:8] first.
- R3: A byte write (host_wr_byte=1) with tx_count below DEPTH adds 1 and queues host_wdata[7:0]. Bytes leave in the order they were written, across word and byte writes.
- R4: A word write with tx_count above DEPTH-2, or a byte write with tx_count equal to DEPTH, is discarded. tx_count is unchanged, ev_overflow pulses in the next cycle, and no write event or kick is raised.
- R5: A pop with tx_count nonzero puts the oldest queued byte on seq_tx_byte and raises seq_tx_valid in the next cycle, and tx_count drops by 1. A pop with tx_count zero raises no seq_tx_valid.
- R6: A push stores seq_rx_byte above the bytes already received and adds 1 to rx_count. A push with rx_count equal to DEPTH is dropped and pulses ev_overflow.
- R7: A read returns the two oldest received bytes on host_rdata with host_rvalid one cycle later, and lowers rx_count by 2. With ctl_swap=0 the earlier byte is in bits 7:0; with ctl_swap=1 it is in bits 15:8. If only one byte is held, the other half is zero and rx_count becomes 0.
- R8: A read with rx_count zero returns 0, leaves rx_count at 0 and pulses ev_sbd_set.
- R9: Every accepted read pulses ev_rrdy_clr, ev_rovr_clr and ev_kick. When master_rx is high it also pulses ev_ardy_set and ev_mst_clr.
- R10: Every accepted write pulses ev_xudf_clr, ev_xrdy_clr and ev_kick.
- R11: A read in the same cycle as a write is ignored, so no host_rvalid follows and rx_count is unchanged. A pop or push in the same cycle as any host access is ignored.
- R12: tx_count and rx_count never exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_swap | input | 1 | Byte-order select for host words |
| master_rx | input | 1 | Controller is acting as master receiver |
| host_wr | input | 1 | Host write strobe |
| host_wr_byte | input | 1 | Write carries one byte only (bits 7:0) |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data updated this cycle |
| seq_pop | input | 1 | Sequencer takes one outgoing byte |
| seq_tx_byte | output | 8 | Outgoing byte |
| seq_tx_valid | output | 1 | seq_tx_byte updated this cycle |
| seq_push | input | 1 | Sequencer delivers one received byte |
| seq_rx_byte | input | 8 | Received byte |
| tx_count | output | 3 | Outgoing bytes held |
| rx_count | output | 3 | Received bytes held |
| ev_xudf_clr | output | 1 | Clear transmit underflow |
| ev_xrdy_clr | output | 1 | Clear transmit ready |
| ev_rrdy_clr | output | 1 | Clear receive ready |
| ev_rovr_clr | output | 1 | Clear receive overrun |
| ev_sbd_set | output | 1 | Read of empty store |
| ev_ardy_set | output | 1 | Set access ready |
| ev_mst_clr | output | 1 | Clear master flag |
| ev_kick | output | 1 | Restart the sequencer |
| ev_overflow | output | 1 | An access was dropped for lack of room |

## Verification
The hardest situations to reach are the boundaries where the store is nearly full, because each boundary needs a particular mix of word and byte writes first. The bench gets there with a byte write on top of a word write, which leaves an odd count of three, and then tries a word write that does not fit. It does the same with four pushes followed by a fifth. It also issues a host access and a sequencer strobe in the same cycle, then checks that the strobe left no trace on the counts or valid outputs.

// File: rtl/i2cdp_pkg.sv
package i2cdp_pkg;

  // One-cycle event pulses handed to the neighbouring status logic
  typedef struct packed {
    logic xudf_clr;
    logic xrdy_clr;
    logic rrdy_clr;
    logic rovr_clr;
    logic sbd_set;
    logic ardy_set;
    logic mst_clr;
    logic kick;
    logic overflow;
  } evt_t;

  localparam evt_t EVT_NONE = '0;

endpackage

// File: rtl/i2cdp_lane_swap.sv
// Reverses the byte lanes of a word when rev is high.
module i2cdp_lane_swap #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      rev,
  input  logic [BYTE_W*LANES-1:0]   din,
  output logic [BYTE_W*LANES-1:0]   dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*BYTE_W +: BYTE_W] = rev ? din[(LANES-1-g)*BYTE_W +: BYTE_W]
                                          : din[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/i2cdp_ctrl.sv
// Decides which accesses are accepted and registers the event pulses.
module i2cdp_ctrl
  import i2cdp_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int HALF  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_rx,
  input  logic             host_wr,
  input  logic             host_wr_byte,
  input  logic             host_rd,
  input  logic             seq_pop,
  input  logic             seq_push,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  output logic             wr_word_ok,
  output logic             wr_one_ok,
  output logic             rd_ok,
  output logic             pop_ok,
  output logic             push_ok,
  output evt_t             evt_q
);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(DEPTH - HALF);

  logic host_busy, wr_ok, drop;
  evt_t evt_n;

  always_comb begin
    host_busy  = host_wr | host_rd;
    wr_word_ok = host_wr & ~host_wr_byte & (tx_cnt <= WORD_LIM);
    wr_one_ok  = host_wr &  host_wr_byte & (tx_cnt <  FULL);
    wr_ok      = wr_word_ok | wr_one_ok;
    rd_ok      = host_rd & ~host_wr;
    pop_ok     = seq_pop  & ~host_busy & (tx_cnt != '0);
    push_ok    = seq_push & ~host_busy & (rx_cnt != FULL);
    drop       = (host_wr & ~wr_ok) | (seq_push & ~host_busy & (rx_cnt == FULL));

    evt_n          = EVT_NONE;
    evt_n.xudf_clr = wr_ok;
    evt_n.xrdy_clr = wr_ok;
    evt_n.rrdy_clr = rd_ok;
    evt_n.rovr_clr = rd_ok;
    evt_n.sbd_set  = rd_ok & (rx_cnt == '0);
    evt_n.ardy_set = rd_ok & master_rx;
    evt_n.mst_clr  = rd_ok & master_rx;
    evt_n.kick     = wr_ok | rd_ok;
    evt_n.overflow = drop;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= EVT_NONE;
    else     evt_q <= evt_n;
  end
endmodule

// File: rtl/i2cdp_store.sv
// Shared byte store with separate outgoing and incoming occupancy counts.
module i2cdp_store #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  parameter int HALF   = 2,
  parameter int CNT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_word,
  input  logic                     wr_one,
  input  logic [BYTE_W*HALF-1:0]   word_in,
  input  logic [BYTE_W-1:0]        byte_in,
  input  logic                     rd_take,
  input  logic                     pop_take,
  input  logic                     push_take,
  input  logic [BYTE_W-1:0]        rx_byte,
  output logic [BYTE_W-1:0]        tx_byte_q,
  output logic                     tx_valid_q,
  output logic [BYTE_W*HALF-1:0]   head_word,
  output logic [CNT_W-1:0]         tx_cnt,
  output logic [CNT_W-1:0]         rx_cnt
);
  localparam int BUF_W  = BYTE_W * DEPTH;
  localparam int HOST_W = BYTE_W * HALF;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(HALF);

  logic [BUF_W-1:0]  buf_q, buf_n;
  logic [CNT_W-1:0]  tx_n, rx_n;
  logic [BYTE_W-1:0] pop_byte;

  // oldest outgoing byte sits just below the outgoing count
  always_comb begin
    pop_byte = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i + 1) == tx_cnt) pop_byte = buf_q[i*BYTE_W +: BYTE_W];
  end

  // lowest received lanes, with lanes not yet filled forced to zero
  always_comb begin
    for (int i = 0; i < HALF; i++)
      head_word[i*BYTE_W +: BYTE_W] = (CNT_W'(i) < rx_cnt) ? buf_q[i*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    buf_n = buf_q;
    tx_n  = tx_cnt;
    rx_n  = rx_cnt;
    if (wr_word) begin
      buf_n = (buf_q << HOST_W) | BUF_W'(word_in);
      tx_n  = tx_cnt + STEP;
    end else if (wr_one) begin
      buf_n = (buf_q << BYTE_W) | BUF_W'(byte_in);
      tx_n  = tx_cnt + CNT_W'(1);
    end else if (rd_take) begin
      buf_n = buf_q >> HOST_W;
      rx_n  = (rx_cnt >= STEP) ? rx_cnt - STEP : '0;
    end else begin
      if (pop_take) tx_n = tx_cnt - CNT_W'(1);
      if (push_take) begin
        for (int i = 0; i < DEPTH; i++)
          if (CNT_W'(i) == rx_cnt) buf_n[i*BYTE_W +: BYTE_W] = rx_byte;
        rx_n = rx_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q      <= '0;
      tx_cnt     <= '0;
      rx_cnt     <= '0;
      tx_byte_q  <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      buf_q      <= buf_n;
      tx_cnt     <= tx_n;
      rx_cnt     <= rx_n;
      tx_valid_q <= pop_take;
      if (pop_take) tx_byte_q <= pop_byte;
    end
  end
endmodule

// File: rtl/i2cdp_buffer.sv
module i2cdp_buffer
  import i2cdp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  parameter int HALF   = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int HOST_W = BYTE_W * HALF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_swap,
  input  logic              master_rx,
  input  logic              host_wr,
  input  logic              host_wr_byte,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              seq_pop,
  output logic [BYTE_W-1:0] seq_tx_byte,
  output logic              seq_tx_valid,
  input  logic              seq_push,
  input  logic [BYTE_W-1:0] seq_rx_byte,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              ev_xudf_clr,
  output logic              ev_xrdy_clr,
  output logic              ev_rrdy_clr,
  output logic              ev_rovr_clr,
  output logic              ev_sbd_set,
  output logic              ev_ardy_set,
  output logic              ev_mst_clr,
  output logic              ev_kick,
  output logic              ev_overflow
);
  logic wr_word_ok, wr_one_ok, rd_ok, pop_ok, push_ok;
  logic [HOST_W-1:0] word_packed, head_word, head_host;
  evt_t evt;

  i2cdp_ctrl #(.DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .master_rx(master_rx),
    .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_rd(host_rd),
    .seq_pop(seq_pop), .seq_push(seq_push),
    .tx_cnt(tx_count), .rx_cnt(rx_count),
    .wr_word_ok(wr_word_ok), .wr_one_ok(wr_one_ok), .rd_ok(rd_ok),
    .pop_ok(pop_ok), .push_ok(push_ok), .evt_q(evt)
  );

  // write side: the lane sent first must land in the upper store lane
  i2cdp_lane_swap #(.BYTE_W(BYTE_W), .LANES(HALF)) u_wr_swap (
    .rev(~ctl_swap), .din(host_wdata), .dout(word_packed)
  );

  // read side: the earliest byte sits in the lowest store lane
  i2cdp_lane_swap #(.BYTE_W(BYTE_W), .LANES(HALF)) u_rd_swap (
    .rev(ctl_swap), .din(head_word), .dout(head_host)
  );

  i2cdp_store #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_word(wr_word_ok), .wr_one(wr_one_ok),
    .word_in(word_packed), .byte_in(host_wdata[BYTE_W-1:0]),
    .rd_take(rd_ok), .pop_take(pop_ok), .push_take(push_ok),
    .rx_byte(seq_rx_byte),
    .tx_byte_q(seq_tx_byte), .tx_valid_q(seq_tx_valid),
    .head_word(head_word), .tx_cnt(tx_count), .rx_cnt(rx_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_ok;
      if (rd_ok) host_rdata <= head_host;
    end
  end

  assign ev_xudf_clr = evt.xudf_clr;
  assign ev_xrdy_clr = evt.xrdy_clr;
  assign ev_rrdy_clr = evt.rrdy_clr;
  assign ev_rovr_clr = evt.rovr_clr;
  assign ev_sbd_set  = evt.sbd_set;
  assign ev_ardy_set = evt.ardy_set;
  assign ev_mst_clr  = evt.mst_clr;
  assign ev_kick     = evt.kick;
  assign ev_overflow = evt.overflow;
endmodule

// File: rtl/i2cdp_buffer_chk.sv
module i2cdp_buffer_chk #(
  parameter int DEPTH  = 4,
  parameter int HALF   = 2,
  parameter int CNT_W  = 3,
  parameter int HOST_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              master_rx,
  input logic              host_wr,
  input logic              host_wr_byte,
  input logic              host_rd,
  input logic [HOST_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              seq_pop,
  input logic              seq_tx_valid,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic              ev_sbd_set,
  input logic              ev_ardy_set,
  input logic              ev_mst_clr,
  input logic              ev_kick,
  input logic              ev_overflow
);
  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

  // R2
  word_accept_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr && !host_wr_byte && (tx_count <= CNT_W'(DEPTH - HALF))
    |=> (tx_count == $past(tx_count) + CNT_W'(HALF)) && ev_kick);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr && !host_wr_byte && (tx_count > CNT_W'(DEPTH - HALF))
    |=> ev_overflow && $stable(tx_count) && !ev_kick);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_wr && (rx_count == '0)
    |=> ev_sbd_set && (host_rdata == '0) && (rx_count == '0));

  // R9
  master_read_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd && !host_wr && master_rx |=> ev_ardy_set && ev_mst_clr);

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    seq_pop && !host_wr && !host_rd && (tx_count == '0) |=> !seq_tx_valid);

  // R11
  rd_collide_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_rd |=> !host_rvalid && $stable(rx_count));
endmodule

bind i2cdp_buffer i2cdp_buffer_chk #(
  .DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W), .HOST_W(HOST_W)
) u_chk (
  .clk(clk), .rst(rst), .master_rx(master_rx),
  .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_rd(host_rd),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .seq_pop(seq_pop), .seq_tx_valid(seq_tx_valid),
  .tx_count(tx_count), .rx_count(rx_count),
  .ev_sbd_set(ev_sbd_set), .ev_ardy_set(ev_ardy_set), .ev_mst_clr(ev_mst_clr),
  .ev_kick(ev_kick), .ev_overflow(ev_overflow)
);

// File: tb/i2cdp_buffer_tb.sv
module i2cdp_buffer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_swap = 0, master_rx = 0, host_wr = 0, host_wr_byte = 0, host_rd = 0;
  logic seq_pop = 0, seq_push = 0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  seq_rx_byte = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid, seq_tx_valid;
  logic [7:0]  seq_tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic ev_xudf_clr, ev_xrdy_clr, ev_rrdy_clr, ev_rovr_clr, ev_sbd_set;
  logic ev_ardy_set, ev_mst_clr, ev_kick, ev_overflow;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2cdp_buffer u_dut (
    .clk(clk), .rst(rst), .ctl_swap(ctl_swap), .master_rx(master_rx),
    .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .seq_pop(seq_pop), .seq_tx_byte(seq_tx_byte), .seq_tx_valid(seq_tx_valid),
    .seq_push(seq_push), .seq_rx_byte(seq_rx_byte),
    .tx_count(tx_count), .rx_count(rx_count),
    .ev_xudf_clr(ev_xudf_clr), .ev_xrdy_clr(ev_xrdy_clr), .ev_rrdy_clr(ev_rrdy_clr),
    .ev_rovr_clr(ev_rovr_clr), .ev_sbd_set(ev_sbd_set), .ev_ardy_set(ev_ardy_set),
    .ev_mst_clr(ev_mst_clr), .ev_kick(ev_kick), .ev_overflow(ev_overflow)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // ops: 0 word write, 1 byte write, 2 pop, 3 push, 4 read
  localparam int OP_W16 = 0, OP_W8 = 1, OP_POP = 2, OP_PUSH = 3, OP_RD = 4;

  task automatic step(input int op, input logic swap, input logic [15:0] d);
    @(negedge clk);
    ctl_swap     = swap;
    host_wr      = (op == OP_W16) || (op == OP_W8);
    host_wr_byte = (op == OP_W8);
    host_wdata   = d;
    seq_pop      = (op == OP_POP);
    seq_push     = (op == OP_PUSH);
    seq_rx_byte  = d[7:0];
    host_rd      = (op == OP_RD);
    @(posedge clk);
    #1;
    host_wr = 0; host_wr_byte = 0; seq_pop = 0; seq_push = 0; host_rd = 0;
  endtask

  // {op[2:0], swap, data[15:0], expected[15:0]}
  localparam logic [35:0] VEC [0:20] = '{
    {3'd0, 1'b0, 16'h2211, 16'h0002},  // R2 word write
    {3'd1, 1'b0, 16'h0033, 16'h0003},  // R3 byte write
    {3'd2, 1'b0, 16'h0000, 16'h0011},  // R2 low lane first
    {3'd2, 1'b0, 16'h0000, 16'h0022},
    {3'd2, 1'b0, 16'h0000, 16'h0033},  // R3 byte last
    {3'd0, 1'b1, 16'h4455, 16'h0002},
    {3'd2, 1'b0, 16'h0000, 16'h0044},  // R2 swapped: high lane first
    {3'd2, 1'b0, 16'h0000, 16'h0055},
    {3'd3, 1'b0, 16'h00A1, 16'h0001},  // R6 pushes
    {3'd3, 1'b0, 16'h00B2, 16'h0002},
    {3'd3, 1'b0, 16'h00C3, 16'h0003},
    {3'd4, 1'b0, 16'h0000, 16'hB2A1},  // R7 earlier byte low
    {3'd4, 1'b1, 16'h0000, 16'hC300},  // R7 single byte, swapped
    {3'd3, 1'b0, 16'h0001, 16'h0001},
    {3'd3, 1'b0, 16'h0002, 16'h0002},
    {3'd4, 1'b1, 16'h0000, 16'h0102},  // R7 earlier byte high
    {3'd1, 1'b0, 16'h0077, 16'h0001},
    {3'd0, 1'b1, 16'h8899, 16'h0003},
    {3'd2, 1'b0, 16'h0000, 16'h0077},  // R3 order across write sizes
    {3'd2, 1'b0, 16'h0000, 16'h0088},
    {3'd2, 1'b0, 16'h0000, 16'h0099}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 counts", {10'b0, tx_count, rx_count}, 16'h0000);
    chk("R1 valids/events", {5'b0, host_rvalid, seq_tx_valid, ev_xudf_clr, ev_xrdy_clr,
        ev_rrdy_clr, ev_rovr_clr, ev_sbd_set, ev_ardy_set, ev_mst_clr, ev_kick, ev_overflow},
        16'h0000);

    for (int i = 0; i < 21; i++) begin
      step(int'(VEC[i][35:33]), VEC[i][32], VEC[i][31:16]);
      case (int'(VEC[i][35:33]))
        OP_W16, OP_W8: chk("R2/R3 tx_count", {13'b0, tx_count}, VEC[i][15:0]);
        OP_POP:  chk("R5 pop byte", {7'b0, seq_tx_valid, seq_tx_byte}, {7'b0, 1'b1, VEC[i][7:0]});
        OP_PUSH: chk("R6 rx_count", {13'b0, rx_count}, VEC[i][15:0]);
        default: chk("R7 read data", host_rdata, VEC[i][15:0]);
      endcase
    end
    chk("R7 counts drained", {10'b0, tx_count, rx_count}, 16'h0000);

    // R10 write events, then R4 overflow on full/odd counts
    step(OP_W16, 0, 16'hBEEF);
    chk("R10 write events", {13'b0, ev_xudf_clr, ev_xrdy_clr, ev_kick}, 16'h0007);
    step(OP_W8, 0, 16'h0034);
    chk("R3 odd count", {13'b0, tx_count}, 16'h0003);
    step(OP_W16, 0, 16'h5678);
    chk("R4 word overflow", {12'b0, ev_overflow, tx_count}, 16'h000B);
    chk("R4 no write events", {13'b0, ev_xudf_clr, ev_xrdy_clr, ev_kick}, 16'h0000);
    step(OP_W8, 0, 16'h0012);
    step(OP_W8, 0, 16'h0099);
    chk("R4 byte overflow", {12'b0, ev_overflow, tx_count}, 16'h000C);
    step(OP_POP, 0, 0); chk("R3 drain 1", {8'b0, seq_tx_byte}, 16'h00EF);
    step(OP_POP, 0, 0); chk("R3 drain 2", {8'b0, seq_tx_byte}, 16'h00BE);
    step(OP_POP, 0, 0); chk("R3 drain 3", {8'b0, seq_tx_byte}, 16'h0034);
    step(OP_POP, 0, 0); chk("R3 drain 4", {8'b0, seq_tx_byte}, 16'h0012);
    step(OP_POP, 0, 0);
    chk("R5 empty pop", {12'b0, seq_tx_valid, tx_count}, 16'h0000);

    // R6 full receive, R9 read events, R8 empty read
    step(OP_PUSH, 0, 16'h0010);
    step(OP_PUSH, 0, 16'h0020);
    step(OP_PUSH, 0, 16'h0030);
    step(OP_PUSH, 0, 16'h0040);
    step(OP_PUSH, 0, 16'h0050);
    chk("R6 push overflow", {12'b0, ev_overflow, rx_count}, 16'h000C);
    master_rx = 1;
    step(OP_RD, 0, 0);
    chk("R7 full read", host_rdata, 16'h2010);
    chk("R9 master read events", {10'b0, ev_rrdy_clr, ev_rovr_clr, ev_ardy_set, ev_mst_clr,
        ev_kick, ev_sbd_set}, 16'h003E);
    master_rx = 0;
    step(OP_RD, 0, 0);
    chk("R9 plain read events", {10'b0, ev_rrdy_clr, ev_rovr_clr, ev_ardy_set, ev_mst_clr,
        ev_kick, ev_sbd_set}, 16'h0032);
    chk("R7 second read", host_rdata, 16'h4030);
    step(OP_RD, 0, 0);
    chk("R8 empty read", host_rdata, 16'h0000);
    chk("R8 empty flags", {11'b0, host_rvalid, ev_sbd_set, rx_count}, 16'h0018);

    // R11 collisions
    step(OP_PUSH, 0, 16'h005A);
    @(negedge clk);
    host_wr = 1; host_wdata = 16'h1111; host_rd = 1;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0;
    chk("R11 read under write", {9'b0, host_rvalid, tx_count, rx_count}, 16'h0011);
    @(negedge clk);
    host_wr = 1; host_wdata = 16'h2222; seq_pop = 1; seq_push = 1; seq_rx_byte = 8'h77;
    @(posedge clk); #1;
    host_wr = 0; seq_pop = 0; seq_push = 0;
    chk("R11 sequencer under write", {9'b0, seq_tx_valid, tx_count, rx_count}, 16'h0021);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule